// File: doc/BRIEF.md
# Dual-Role USB Role Selection Controller

This block decides whether a dual-role USB controller runs as host or as peripheral for the length of one session. A session is requested in one of two ways. The analog comparator can report a valid VBUS level, or firmware can set a session-request bit. Both requests have the same effect. The controller has two sources for the identification level. One is the physical ID pin, which passes through a multi-flop synchronizer and a programmable stability filter. The other is a firmware override, which replaces the pin completely.

A session moves through three steps. The request opens the session. The controller then waits until the chosen identification level is usable. At that point it captures the role once and holds it until the session closes. A low identification level gives the host role. A high level gives the peripheral role. Changes to the pin or to the override registers during a session have no effect on the role. When both session requests drop, the session closes and the role output returns to its idle value.

A typical setup is as follows. With the pin as source, an A-side plug grounds ID and gives host, and a B-side plug leaves ID high and gives peripheral. With the override as source, firmware writes the identification value before it opens the session.

Top module: `otg_role_sel`

## Requirements
- R1: `sess_active_o` is 1 from the first clock edge at which `vbus_valid_i` or `fw_sess_req_i` is high. It drops at the first clock edge at which both are low. At that same edge `role_valid_o` also drops.
- R2: When `id_sw_en_i` is 1, the role is taken from `id_sw_val_i` and `role_valid_o` rises at the second clock edge after the session request is first seen.
- R3: When `id_sw_en_i` is 1, the level of `id_pin_i` has no effect on `role_o`.
- R4: The role encoding is `role_o` = 0 for host and 1 for peripheral. It follows from the identification level: 0 gives host and 1 gives peripheral.
- R5: When `id_sw_en_i` is 0, the role comes from `id_pin_i`. The pin is seen through two flops. A new pin level is accepted only after it has stayed unchanged for `stable_cnt_i` further cycles. If the pin changes before edge p and the request is first seen at edge p+2, `role_valid_o` rises at the (`stable_cnt_i`+2)-th edge counted from that request edge. If the pin has been steady for longer than that, the latency is 2 edges.
- R6: While `role_valid_o` is 1, `role_o` does not change, whatever `id_pin_i`, `id_sw_en_i` or `id_sw_val_i` do.
- R7: While `role_valid_o` is 0, including during reset and after a session ends, `role_o` reads 0.
- R8: `role_valid_o` is never 1 while `sess_active_o` is 0. If the session request drops before the role is captured, no role is ever reported for that attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vbus_valid_i | input | 1 | VBUS-valid indication from the comparator |
| fw_sess_req_i | input | 1 | Firmware session request |
| id_pin_i | input | 1 | Asynchronous ID pin level |
| id_sw_en_i | input | 1 | Select firmware identification value instead of the pin |
| id_sw_val_i | input | 1 | Firmware identification value |
| stable_cnt_i | input | STABLE_W | Extra cycles the synchronized pin must hold before use |
| sess_active_o | output | 1 | Session in progress |
| role_o | output | 1 | Captured role, 0 host, 1 peripheral |
| role_valid_o | output | 1 | Role captured and held |

## Verification
The hardest situation to reach from the ports is a session that opens while a fresh pin level is still moving through the synchronizer and the stability filter. The bench controls this timing exactly. It drives a pin transition, waits two clock edges, and only then raises the request. It does this for every filter setting and both pin levels, and checks the latency and the role against N+2. It also opens a session and drops it while the filter is still counting, to show that no role escapes. After every capture it toggles all identification inputs to show that the held role does not move.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;

    typedef enum logic {
        ROLE_HOST   = 1'b0,
        ROLE_DEVICE = 1'b1
    } role_e;

    typedef enum logic [1:0] {
        SES_IDLE    = 2'd0,
        SES_WAIT_ID = 2'd1,
        SES_ACTIVE  = 2'd2
    } ses_state_e;

    // identification sample offered to the session sequencer
    typedef struct packed {
        logic  ready;
        role_e role;
    } id_sample_t;

    function automatic role_e id_to_role(input logic id_level);
        return id_level ? ROLE_DEVICE : ROLE_HOST;
    endfunction

endpackage

// File: rtl/otg_id_sync.sv
module otg_id_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             level_o,
    output logic             stable_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   synced;
    logic                   level_q;
    logic [CNT_W-1:0]       hold_cnt_q;

    // shift register synchronizer, idle level is high (pulled-up ID)
    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
    end

    assign synced = chain_q[SYNC_STAGES-1];

    // stability filter: restart counting on each change of the synced level
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q    <= 1'b1;
            hold_cnt_q <= '0;
        end else if (synced != level_q) begin
            level_q    <= synced;
            hold_cnt_q <= '0;
        end else if (hold_cnt_q != CNT_MAX) begin
            hold_cnt_q <= hold_cnt_q + 1'b1;
        end
    end

    assign level_o  = level_q;
    assign stable_o = (synced == level_q) && (hold_cnt_q >= limit_i);

endmodule

// File: rtl/otg_id_select.sv
module otg_id_select
    import otg_role_pkg::*;
(
    input  logic       sw_en_i,
    input  logic       sw_val_i,
    input  logic       pin_level_i,
    input  logic       pin_stable_i,
    output id_sample_t sample_o
);
    always_comb begin
        if (sw_en_i) begin
            sample_o.ready = 1'b1;
            sample_o.role  = id_to_role(sw_val_i);
        end else begin
            sample_o.ready = pin_stable_i;
            sample_o.role  = id_to_role(pin_level_i);
        end
    end
endmodule

// File: rtl/otg_session_fsm.sv
module otg_session_fsm
    import otg_role_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sess_req_i,
    input  id_sample_t sample_i,
    output logic       sess_active_o,
    output role_e      role_o,
    output logic       role_valid_o
);
    ses_state_e state_q, state_d;
    role_e      role_q, role_d;

    always_comb begin
        state_d = state_q;
        role_d  = role_q;
        unique case (state_q)
            SES_IDLE: begin
                if (sess_req_i) state_d = SES_WAIT_ID;
            end
            SES_WAIT_ID: begin
                if (!sess_req_i) begin
                    state_d = SES_IDLE;
                end else if (sample_i.ready) begin
                    state_d = SES_ACTIVE;
                    role_d  = sample_i.role;
                end
            end
            SES_ACTIVE: begin
                if (!sess_req_i) begin
                    state_d = SES_IDLE;
                    role_d  = ROLE_HOST;
                end
            end
            default: begin
                state_d = SES_IDLE;
                role_d  = ROLE_HOST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SES_IDLE;
            role_q  <= ROLE_HOST;
        end else begin
            state_q <= state_d;
            role_q  <= role_d;
        end
    end

    assign sess_active_o = (state_q != SES_IDLE);
    assign role_valid_o  = (state_q == SES_ACTIVE);
    assign role_o        = role_q;

endmodule

// File: rtl/otg_role_sel.sv
module otg_role_sel
    import otg_role_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vbus_valid_i,
    input  logic                fw_sess_req_i,
    input  logic                id_pin_i,
    input  logic                id_sw_en_i,
    input  logic                id_sw_val_i,
    input  logic [STABLE_W-1:0] stable_cnt_i,
    output logic                sess_active_o,
    output logic                role_o,
    output logic                role_valid_o
);
    logic       pin_level;
    logic       pin_stable;
    logic       sess_req;
    id_sample_t sample;
    role_e      role_held;

    assign sess_req = vbus_valid_i | fw_sess_req_i;

    otg_id_sync #(
        .SYNC_STAGES (SYNC_STAGES),
        .CNT_W       (STABLE_W)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_i    (id_pin_i),
        .limit_i  (stable_cnt_i),
        .level_o  (pin_level),
        .stable_o (pin_stable)
    );

    otg_id_select u_sel (
        .sw_en_i      (id_sw_en_i),
        .sw_val_i     (id_sw_val_i),
        .pin_level_i  (pin_level),
        .pin_stable_i (pin_stable),
        .sample_o     (sample)
    );

    otg_session_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .sess_req_i    (sess_req),
        .sample_i      (sample),
        .sess_active_o (sess_active_o),
        .role_o        (role_held),
        .role_valid_o  (role_valid_o)
    );

    assign role_o = role_held;

endmodule

// File: rtl/otg_role_sel_chk.sv
module otg_role_sel_chk (
    input logic clk,
    input logic rst,
    input logic vbus_valid_i,
    input logic fw_sess_req_i,
    input logic id_sw_en_i,
    input logic id_sw_val_i,
    input logic sess_active_o,
    input logic role_o,
    input logic role_valid_o
);
    assert_session_ends_R1: assert property (@(posedge clk) disable iff (rst)
        (!vbus_valid_i && !fw_sess_req_i) |=> (!sess_active_o && !role_valid_o));

    assert_session_opens_R1: assert property (@(posedge clk) disable iff (rst)
        (vbus_valid_i || fw_sess_req_i) |=> sess_active_o);

    assert_sw_value_taken_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(role_valid_o) && $past(id_sw_en_i)) |-> (role_o == $past(id_sw_val_i)));

    assert_role_held_R6: assert property (@(posedge clk) disable iff (rst)
        role_valid_o |=> (!role_valid_o || $stable(role_o)));

    assert_idle_role_R7: assert property (@(posedge clk) disable iff (rst)
        !role_valid_o |-> !role_o);

    assert_valid_in_session_R8: assert property (@(posedge clk) disable iff (rst)
        role_valid_o |-> sess_active_o);
endmodule

bind otg_role_sel otg_role_sel_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .vbus_valid_i  (vbus_valid_i),
    .fw_sess_req_i (fw_sess_req_i),
    .id_sw_en_i    (id_sw_en_i),
    .id_sw_val_i   (id_sw_val_i),
    .sess_active_o (sess_active_o),
    .role_o        (role_o),
    .role_valid_o  (role_valid_o)
);

// File: tb/otg_role_sel_tb.sv
module otg_role_sel_tb_top;
    localparam int STABLE_W = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                vbus_valid_i = 1'b0;
    logic                fw_sess_req_i = 1'b0;
    logic                id_pin_i = 1'b1;
    logic                id_sw_en_i = 1'b0;
    logic                id_sw_val_i = 1'b0;
    logic [STABLE_W-1:0] stable_cnt_i = '0;
    logic                sess_active_o;
    logic                role_o;
    logic                role_valid_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5ns clk = ~clk;

    otg_role_sel #(.SYNC_STAGES(2), .STABLE_W(STABLE_W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .vbus_valid_i  (vbus_valid_i),
        .fw_sess_req_i (fw_sess_req_i),
        .id_pin_i      (id_pin_i),
        .id_sw_en_i    (id_sw_en_i),
        .id_sw_val_i   (id_sw_val_i),
        .stable_cnt_i  (stable_cnt_i),
        .sess_active_o (sess_active_o),
        .role_o        (role_o),
        .role_valid_o  (role_valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic end_session();
        vbus_valid_i  = 1'b0;
        fw_sess_req_i = 1'b0;
        @(negedge clk);
        chk(sess_active_o == 1'b0, "R1 session closed", sess_active_o, 0);
        chk(role_valid_o == 1'b0, "R1 valid dropped", role_valid_o, 0);
        chk(role_o == 1'b0, "R7 role released", role_o, 0);
        repeat (2) @(negedge clk);
    endtask

    // raise one request source, measure edges until role_valid_o
    task automatic open_session(input bit use_vbus, input int exp_lat, input bit exp_role,
                                input string tag);
        int lat = 0;
        if (use_vbus) vbus_valid_i = 1'b1;
        else          fw_sess_req_i = 1'b1;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (i == 1) chk(sess_active_o == 1'b1, "R1 session opened", sess_active_o, 1);
            if (!role_valid_o) chk(role_o == 1'b0, "R7 role idle while waiting", role_o, 0);
            if (role_valid_o && lat == 0) lat = i;
            if (lat != 0) break;
        end
        chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
        chk(role_o == exp_role, {tag, " role R4"}, role_o, exp_role);
    endtask

    // disturb every identification input, role must not move
    task automatic disturb(input bit exp_role);
        for (int k = 0; k < 6; k++) begin
            id_pin_i    = ~id_pin_i;
            id_sw_val_i = ~id_sw_val_i;
            if (k == 3) id_sw_en_i = ~id_sw_en_i;
            @(negedge clk);
            chk(role_valid_o && role_o == exp_role, "R6 role held", role_o, exp_role);
        end
    endtask

    initial begin
        #2_000_000ns;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(sess_active_o == 1'b0, "R1 reset state", sess_active_o, 0);
        chk(role_valid_o == 1'b0, "R8 reset state", role_valid_o, 0);
        chk(role_o == 1'b0, "R7 reset role", role_o, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);

        // firmware override sweep, pin level deliberately unrelated (R2, R3)
        for (int v = 0; v < 2; v++) begin
            for (int src = 0; src < 2; src++) begin
                for (int p = 0; p < 2; p++) begin
                    id_sw_en_i  = 1'b1;
                    id_sw_val_i = v[0];
                    id_pin_i    = p[0];
                    repeat (3) @(negedge clk);
                    open_session(src[0], 2, v[0], "R2 R3 override");
                    disturb(v[0]);
                    end_session();
                end
            end
        end

        // pin sweep: fresh pin edge, request two edges later (R5)
        id_sw_en_i = 1'b0;
        for (int n = 0; n < 16; n++) begin
            for (int v = 0; v < 2; v++) begin
                stable_cnt_i = n[STABLE_W-1:0];
                id_sw_val_i  = ~v[0];
                id_pin_i     = ~v[0];
                repeat (20) @(negedge clk);
                id_pin_i = v[0];
                repeat (2) @(negedge clk);
                open_session(n[0], n + 2, v[0], "R5 pin filter");
                disturb(v[0]);
                id_sw_en_i = 1'b0;
                end_session();
            end
        end

        // long-steady pin gives minimum latency (R5)
        id_sw_en_i   = 1'b0;
        stable_cnt_i = 4'd9;
        id_pin_i     = 1'b0;
        repeat (25) @(negedge clk);
        open_session(1'b1, 2, 1'b0, "R5 steady pin");
        end_session();

        // request dropped while filter still counting: no role (R8)
        stable_cnt_i = 4'd15;
        id_pin_i     = 1'b1;
        repeat (2) @(negedge clk);
        fw_sess_req_i = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(role_valid_o == 1'b0, "R8 no early role", role_valid_o, 0);
        end
        fw_sess_req_i = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(!role_valid_o && !sess_active_o, "R8 aborted attempt", role_valid_o, 0);
        end

        // one source dropping keeps the session while the other holds (R1)
        id_sw_en_i    = 1'b1;
        id_sw_val_i   = 1'b1;
        fw_sess_req_i = 1'b1;
        open_session(1'b1, 2, 1'b1, "R1 dual source");
        vbus_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(sess_active_o && role_valid_o && role_o, "R1 other source holds", sess_active_o, 1);
        end_session();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule